// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits between a serial-memory protocol controller and a nonvolatile storage array. A write session opens with a start pulse that carries the full word address. Each data byte that follows goes into a page-sized holding buffer, in the slot selected by the low address bits. After each accepted byte, only those low bits of the shared address counter advance. The upper address bits, which select the page, never change during a session.

Nothing reaches the array while bytes are arriving. When the controller signals STOP, the block enters one self-timed programming cycle of fixed length. During that cycle it holds `busy` high, and it emits one array write for each buffer slot that was loaded. Slots that were not loaded produce no write, so the array keeps its old contents there. The controller can use `busy` to withhold its acknowledge while a poll is in progress.

A protect flag sampled with the start pulse locks the session. Its data is then thrown away and STOP starts no cycle. While the cycle runs, the block ignores new starts, data strobes and STOP.

Top module: `page_write_buffer`

## Requirements
- R1: The buffer has 64 slots. A byte is stored in the slot given by address bits [5:0]. It is committed to array address {address bits [13:6] of the session, slot}.
- R2: A start pulse loads `addrOut` with `startAddr`. Each accepted byte increments `addrOut[5:0]` modulo 64 and leaves `addrOut[13:6]` unchanged.
- R3: If more than 64 bytes arrive in one session, the slot index wraps within the page. A later byte replaces the earlier byte in the same slot, so each slot commits the last byte written to it.
- R4: `arrWrEn` never pulses outside the programming cycle. In particular, no array write happens before STOP.
- R5: A STOP in a session that holds at least one loaded byte sets `busy` on the next clock. `busy` then stays high for exactly CYCLE_LEN clocks and clears by itself.
- R6: During the cycle there is exactly one array write per loaded slot, in ascending slot order, and no write for slots that were not loaded.
- R7: A session with a single byte commits just that one byte, as a page write of length one.
- R8: A start with `protectIn` high locks the session. Its bytes are discarded, `addrOut` does not advance, and STOP starts no cycle.
- R9: While `busy` is high, `startWr`, `dataStrobe` and `stopPulse` have no effect. `addrOut` holds its value and the cycle is neither restarted nor extended.
- R10: A STOP in a session with no loaded byte starts no cycle.
- R11: After reset, `busy`, `arrWrEn` and `addrOut` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startWr | input | 1 | Start-of-write pulse; opens a session |
| startAddr | input | 14 | Word address of the session, sampled with `startWr` |
| protectIn | input | 1 | Target page protected, sampled with `startWr` |
| dataStrobe | input | 1 | One data byte available on `dataIn` |
| dataIn | input | 8 | Data byte |
| stopPulse | input | 1 | STOP seen on the bus |
| busy | output | 1 | Programming cycle in progress |
| arrWrEn | output | 1 | Array write strobe |
| arrWrAddr | output | 14 | Array write address |
| arrWrData | output | 8 | Array write data |
| addrOut | output | 14 | Shared address counter value |

## Verification
The main function is tested with four input patterns:
- A one-byte session, which shows that the slot is mapped correctly and that no other slot is written.
- A short run of three bytes, which shows that writes come out in order and that unloaded neighbours are left alone.
- A 70-byte session that starts near the top of a page, which separates a correct in-page wrap (last writer wins, page bits kept) from a carry into the page bits or a dropped byte.
- A session that runs into the timed cycle while new starts, bytes and STOP are still arriving, which shows whether those inputs could shift the address or stretch the cycle.

Protected and empty sessions are checked to confirm that they leave `busy` low and produce no array write at all.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef struct packed {
    logic loadAddr;
    logic storeByte;
    logic progActive;
    logic scanEn;
  } pwbStrobes_t;
endpackage

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
  import pwb_pkg::*;
#(
  parameter int PAGE_BITS = 6,
  parameter int CYCLE_LEN = 100
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startWr,
  input  logic                 protectIn,
  input  logic                 dataStrobe,
  input  logic                 stopPulse,
  input  logic                 anyValid,
  output pwbStrobes_t          strb,
  output logic [PAGE_BITS-1:0] scanIdx,
  output logic                 busy
);
  localparam int PAGE_SIZE = 1 << PAGE_BITS;
  localparam int LEN_W     = $clog2(CYCLE_LEN + 1);
  localparam int CNT_W     = (LEN_W > PAGE_BITS) ? LEN_W : PAGE_BITS + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_PROG} ctrlState_t;

  ctrlState_t state;
  logic [CNT_W-1:0] cnt;
  logic locked;
  logic commitGo;

  always_comb begin
    strb.loadAddr   = startWr && (state != ST_PROG);
    strb.storeByte  = dataStrobe && (state == ST_LOAD) && !locked && !startWr;
    strb.progActive = (state == ST_PROG);
    strb.scanEn     = (state == ST_PROG) && (cnt < CNT_W'(PAGE_SIZE));
    commitGo        = stopPulse && (state == ST_LOAD) && !locked && anyValid && !startWr;
    scanIdx         = cnt[PAGE_BITS-1:0];
    busy            = (state == ST_PROG);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      locked <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (strb.loadAddr) begin
            state  <= ST_LOAD;
            locked <= protectIn;
          end
        end
        ST_LOAD: begin
          if (strb.loadAddr) begin
            locked <= protectIn;
          end else if (commitGo) begin
            state <= ST_PROG;
            cnt   <= '0;
          end else if (stopPulse) begin
            state <= ST_IDLE;
          end
        end
        ST_PROG: begin
          if (cnt == CNT_W'(CYCLE_LEN - 1)) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: the cycle only begins on a STOP
  a_r5_rise_on_stop: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopPulse));

  // R10: the cycle only begins with loaded data
  a_r10_rise_needs_data: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(anyValid));

  // R8: a locked session never commits
  a_r8_locked_no_commit: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !$past(locked));
endmodule

// File: rtl/pwb_datapath.sv
module pwb_datapath
  import pwb_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int DATA_W    = 8,
  parameter int PAGE_BITS = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pwbStrobes_t          strb,
  input  logic [PAGE_BITS-1:0] scanIdx,
  input  logic [ADDR_W-1:0]    startAddr,
  input  logic [DATA_W-1:0]    dataIn,
  output logic                 anyValid,
  output logic [ADDR_W-1:0]    addrOut,
  output logic                 arrWrEn,
  output logic [ADDR_W-1:0]    arrWrAddr,
  output logic [DATA_W-1:0]    arrWrData
);
  localparam int PAGE_SIZE = 1 << PAGE_BITS;
  localparam int HI_W      = ADDR_W - PAGE_BITS;

  logic [DATA_W-1:0]    pageBuf [PAGE_SIZE];
  logic [PAGE_SIZE-1:0] validBits;
  logic [ADDR_W-1:0]    addrReg;
  logic [PAGE_BITS-1:0] slotIdx;
  logic [HI_W-1:0]      pageSel;

  assign slotIdx  = addrReg[PAGE_BITS-1:0];
  assign pageSel  = addrReg[ADDR_W-1:PAGE_BITS];
  assign anyValid = |validBits;
  assign addrOut  = addrReg;

  generate
    for (genvar i = 0; i < PAGE_SIZE; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if (strb.storeByte && (slotIdx == PAGE_BITS'(i))) pageBuf[i] <= dataIn;
      end
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) validBits[i] <= 1'b0;
        else if (strb.loadAddr) validBits[i] <= 1'b0;
        else if (strb.storeByte && (slotIdx == PAGE_BITS'(i))) validBits[i] <= 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
    end else if (strb.loadAddr) begin
      addrReg <= startAddr;
    end else if (strb.storeByte) begin
      addrReg <= {pageSel, slotIdx + 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      arrWrEn   <= 1'b0;
      arrWrAddr <= '0;
      arrWrData <= '0;
    end else begin
      arrWrEn   <= strb.scanEn && validBits[scanIdx];
      arrWrAddr <= {pageSel, scanIdx};
      arrWrData <= pageBuf[scanIdx];
    end
  end

  // R2: page bits survive every accepted byte
  a_r2_upper_kept: assert property (@(posedge clk) disable iff (!rstN)
    strb.storeByte |=> addrReg[ADDR_W-1:PAGE_BITS] == $past(addrReg[ADDR_W-1:PAGE_BITS]));

  // R9: address frozen during the timed cycle
  a_r9_addr_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (strb.progActive && $past(strb.progActive)) |-> $stable(addrReg));

  // R4: array strobes only follow an active scan
  a_r4_wr_in_prog: assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn |-> $past(strb.scanEn));
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer
  import pwb_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int DATA_W    = 8,
  parameter int PAGE_BITS = 6,
  parameter int CYCLE_LEN = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startWr,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              protectIn,
  input  logic              dataStrobe,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              stopPulse,
  output logic              busy,
  output logic              arrWrEn,
  output logic [ADDR_W-1:0] arrWrAddr,
  output logic [DATA_W-1:0] arrWrData,
  output logic [ADDR_W-1:0] addrOut
);
  pwbStrobes_t          strb;
  logic [PAGE_BITS-1:0] scanIdx;
  logic                 anyValid;

  pwb_ctrl #(.PAGE_BITS(PAGE_BITS), .CYCLE_LEN(CYCLE_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .startWr(startWr), .protectIn(protectIn),
    .dataStrobe(dataStrobe), .stopPulse(stopPulse), .anyValid(anyValid),
    .strb(strb), .scanIdx(scanIdx), .busy(busy)
  );

  pwb_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .scanIdx(scanIdx),
    .startAddr(startAddr), .dataIn(dataIn), .anyValid(anyValid),
    .addrOut(addrOut), .arrWrEn(arrWrEn), .arrWrAddr(arrWrAddr),
    .arrWrData(arrWrData)
  );
endmodule

// File: tb/tb_page_write_buffer.sv
`timescale 1ns/1ps
module tb_page_write_buffer;
  localparam int CYC = 100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startWr = 1'b0, protectIn = 1'b0, dataStrobe = 1'b0, stopPulse = 1'b0;
  logic [13:0] startAddr = '0;
  logic [7:0]  dataIn = '0;
  logic busy, arrWrEn;
  logic [13:0] arrWrAddr, addrOut;
  logic [7:0]  arrWrData;

  int total = 0, bad = 0;
  int wrCount = 0, earlyWr = 0, orderErr = 0, busyCycles = 0;
  int prevLow = -1;
  logic [7:0] obsMem [0:16383];
  logic [7:0] expMem [0:16383];

  always #2.5 clk = ~clk;

  page_write_buffer #(.CYCLE_LEN(CYC)) dut (
    .clk(clk), .rstN(rstN), .startWr(startWr), .startAddr(startAddr),
    .protectIn(protectIn), .dataStrobe(dataStrobe), .dataIn(dataIn),
    .stopPulse(stopPulse), .busy(busy), .arrWrEn(arrWrEn),
    .arrWrAddr(arrWrAddr), .arrWrData(arrWrData), .addrOut(addrOut)
  );

  always @(negedge clk) begin
    if (busy) busyCycles++;
    else prevLow = -1;
    if (arrWrEn) begin
      obsMem[arrWrAddr] = arrWrData;
      wrCount++;
      if (!busy) earlyWr++;
      if (int'(arrWrAddr[5:0]) <= prevLow) orderErr++;
      prevLow = int'(arrWrAddr[5:0]);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doStart(input logic [13:0] a, input logic p);
    @(negedge clk); startWr = 1'b1; startAddr = a; protectIn = p;
    @(negedge clk); startWr = 1'b0; protectIn = 1'b0;
  endtask

  task automatic doByte(input logic [7:0] d);
    @(negedge clk); dataStrobe = 1'b1; dataIn = d;
    @(negedge clk); dataStrobe = 1'b0;
  endtask

  task automatic doStop();
    @(negedge clk); stopPulse = 1'b1;
    @(negedge clk); stopPulse = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic clearCounts();
    @(negedge clk); wrCount = 0; busyCycles = 0;
  endtask

  task automatic cmpPage(input logic [13:0] base, input string req);
    int errs = 0;
    for (int i = 0; i < 64; i++)
      if (obsMem[{base[13:6], 6'(i)}] !== expMem[{base[13:6], 6'(i)}]) errs++;
    chk(errs == 0, req, errs, 0);
  endtask

  task automatic testReset();
    chk(busy === 1'b0, "R11 busy", busy, 0);
    chk(arrWrEn === 1'b0, "R11 arrWrEn", arrWrEn, 0);
    chk(addrOut === 14'h0, "R11 addrOut", addrOut, 0);
  endtask

  task automatic testSingle();
    clearCounts();
    doStart(14'h0123, 1'b0);
    chk(addrOut === 14'h0123, "R2 load", addrOut, 14'h0123);
    doByte(8'hA5);
    expMem[14'h0123] = 8'hA5;
    chk(addrOut === 14'h0124, "R2 step", addrOut, 14'h0124);
    doStop();
    chk(busy === 1'b1, "R5 busy set", busy, 1);
    waitIdle();
    chk(busyCycles == CYC, "R5 busy length", busyCycles, CYC);
    chk(wrCount == 1, "R7 one write", wrCount, 1);
    cmpPage(14'h0123, "R7 R1 page content");
  endtask

  task automatic testPartial();
    clearCounts();
    doStart(14'h1234, 1'b0);
    for (int i = 0; i < 3; i++) begin
      doByte(8'h10 + 8'(i));
      expMem[14'h1234 + 14'(i)] = 8'h10 + 8'(i);
    end
    chk(wrCount == 0, "R4 nothing before stop", wrCount, 0);
    doStop();
    waitIdle();
    chk(wrCount == 3, "R6 loaded only", wrCount, 3);
    chk(obsMem[14'h1237] === 8'h00, "R6 neighbour kept", obsMem[14'h1237], 0);
    cmpPage(14'h1234, "R6 content");
  endtask

  task automatic testWrap();
    clearCounts();
    doStart(14'h207C, 1'b0);
    for (int i = 0; i < 70; i++) begin
      doByte(8'h40 + 8'(i));
      expMem[{8'h81, 6'((60 + i) % 64)}] = 8'h40 + 8'(i);
    end
    chk(addrOut === 14'h2042, "R2 R3 wrapped address", addrOut, 14'h2042);
    chk(wrCount == 0, "R4 no early write", wrCount, 0);
    doStop();
    waitIdle();
    chk(wrCount == 64, "R3 full page", wrCount, 64);
    cmpPage(14'h207C, "R3 R1 last writer wins");
  endtask

  task automatic testProtect();
    clearCounts();
    doStart(14'h3100, 1'b1);
    doByte(8'hEE);
    doByte(8'hEF);
    chk(addrOut === 14'h3100, "R8 address held", addrOut, 14'h3100);
    doStop();
    chk(busy === 1'b0, "R8 no cycle", busy, 0);
    repeat (5) @(negedge clk);
    chk(wrCount == 0, "R8 no writes", wrCount, 0);
  endtask

  task automatic testEmpty();
    clearCounts();
    doStart(14'h0040, 1'b0);
    doStop();
    chk(busy === 1'b0, "R10 no cycle", busy, 0);
    repeat (5) @(negedge clk);
    chk(wrCount == 0, "R10 no writes", wrCount, 0);
  endtask

  task automatic testBusyIgnore();
    clearCounts();
    doStart(14'h0500, 1'b0);
    doByte(8'h11);
    doByte(8'h22);
    expMem[14'h0500] = 8'h11;
    expMem[14'h0501] = 8'h22;
    doStop();
    doStart(14'h3333, 1'b0);
    doByte(8'h99);
    doStop();
    chk(addrOut === 14'h0502, "R9 address frozen", addrOut, 14'h0502);
    waitIdle();
    chk(busyCycles == CYC, "R9 cycle not stretched", busyCycles, CYC);
    chk(wrCount == 2, "R9 writes", wrCount, 2);
    chk(obsMem[14'h3333] === 8'h00, "R9 no stray write", obsMem[14'h3333], 0);
    cmpPage(14'h0500, "R9 content");
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16384; i++) begin
      obsMem[i] = 8'h00;
      expMem[i] = 8'h00;
    end
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testSingle();
    testPartial();
    testWrap();
    testProtect();
    testEmpty();
    testBusyIgnore();
    chk(earlyWr == 0, "R4 writes outside cycle", earlyWr, 0);
    chk(orderErr == 0, "R6 ascending order", orderErr, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule